// File: doc/BRIEF.md
# Cyclic egress gate scheduler

This block drives the eight transmit gates of one egress port from a short, cyclic gate control list. Each list entry carries an 8-bit open-gate mask, with one bit per traffic class, and a duration counted in 200 ns slots. The scheduler compares a free-running nanosecond time input against the slot grid. Once the programmed start slot is reached, it applies entry 0, then entry 1, and so on. After the last active entry it returns to entry 0. The cycle length is therefore the sum of the active entry durations. For example, with entry 0 opening only class 7 for 500 slots and entry 1 opening classes 0 to 6 for 2000 slots, the cycle repeats every 500 us.

Every entry boundary is a gate event. On each event the block raises a one-cycle strobe carrying the event's absolute slot number and the port's index, so that a checker shared by several ports can see the event. The block also checks for collisions itself. If an event of another port and an event of this port fall in the same slot, it raises a conflict flag. It does the same when two of its own consecutive events share a slot, as happens with a zero-length entry. While the scheduler is disabled, or before the start slot arrives, the gates show a programmable idle mask. The list is written through a simple write port, and writes are accepted only while the scheduler is disabled.

Top module: `gate_sched_port`

## Requirements
- R1: While `enable` is low, and while enabled but before the first event, `gate_open` equals `idle_gates` and `evt_strobe` stays low.
- R2: The first event occurs on the first clock edge at which `enable` is high, the scheduler has already spent one cycle armed, and `time_ns >= base_slot*200`. In the cycle after that edge, `gate_open` equals the mask of entry 0, `evt_strobe` is 1 and `evt_slot` equals `base_slot`.
- R3: An entry with duration D that starts at slot S is followed by an event at slot S+D. That event fires on the clock edge at which `time_ns >= (S+D)*200` is first seen, and applies the next entry's mask.
- R4: After entry `n_entries-1`, the next event applies entry 0, so the cycle length is the sum of the active durations. A value of 0 in `n_entries` acts as 1, and a value above the list depth acts as the depth.
- R5: A write (`wr_en`) updates entry `wr_idx`, with mask bit i being class i, only while `enable` is low. A write while enabled changes neither the mask nor the duration of any entry.
- R6: Each event presents the port's index (parameter `PORT_ID`) on `evt_port` and the event's slot number on `evt_slot`. Both are valid in the cycle of `evt_strobe`.
- R7: `conflict` is high in the cycle of an own event when `peer_evt_valid` is high in that cycle with `peer_evt_slot` equal to `evt_slot`. A peer event in a different slot raises no conflict.
- R8: When two consecutive own events share a slot (a zero-duration entry), `conflict` is high with the second event.
- R9: `conflict` is also high when a peer event names the slot of the latest own event, or an own event names the slot of the latest peer event. Histories are cleared while disabled.
- R10: If time has passed several event slots at once, the pending events fire on consecutive clock edges, one per edge and in slot order, until the schedule catches up.
- R11: Dropping `enable` returns `gate_open` to `idle_gates` after the next edge. Raising it again restarts the schedule from entry 0 at `base_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the schedule; low holds idle and unlocks the list |
| time_ns | input | 48 | Free-running time in nanoseconds |
| base_slot | input | 48 | Absolute start slot of the schedule (200 ns units) |
| n_entries | input | 5 | Number of active list entries |
| idle_gates | input | 8 | Gate mask shown while idle or before start |
| wr_en | input | 1 | List write strobe |
| wr_idx | input | 4 | List entry to write |
| wr_gates | input | 8 | Gate mask to write, bit i is class i |
| wr_interval | input | 16 | Entry duration in slots to write |
| peer_evt_valid | input | 1 | Another port reports a gate event |
| peer_evt_slot | input | 48 | Slot of the other port's event |
| gate_open | output | 8 | Current open-gate vector |
| evt_strobe | output | 1 | One-cycle pulse per gate event |
| evt_port | output | 3 | Port index carried with the event |
| evt_slot | output | 48 | Slot number of the event |
| conflict | output | 1 | Two gate events claim the same slot |

## Verification
The bench steps time to one nanosecond before and exactly at each slot boundary. A design that rounds the comparison the wrong way opens the gates a slot early or late. Wrapping from the last entry to entry 0 is checked, and so is a write made while running: a design that honours that write shows a different mask or duration at the wrap. A time jump across several boundaries must yield back-to-back strobes in slot order, where a design that skips to the newest entry loses events. The conflict cases cover a peer event in the same cycle, a peer event arriving after the own event and an own event after the peer's, a peer in a different slot, and a zero-length entry. These catch checkers that compare only one direction or flag every peer event.

// File: rtl/gs_pkg.sv
package gs_pkg;

    localparam int GS_NUM_TC  = 8;
    localparam int GS_IV_W    = 16;
    localparam int GS_TIME_W  = 48;
    localparam int GS_SLOT_NS = 200;

    typedef logic [GS_NUM_TC-1:0] gs_mask_t;
    typedef logic [GS_IV_W-1:0]   gs_iv_t;
    typedef logic [GS_TIME_W-1:0] gs_time_t;

    typedef struct packed {
        gs_mask_t gates;
        gs_iv_t   interval;
    } gs_entry_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RUN  = 2'd2
    } gs_state_e;

    function automatic gs_time_t slot_to_ns(gs_time_t slot);
        return slot * gs_time_t'(GS_SLOT_NS);
    endfunction

endpackage

// File: rtl/gs_gcl_store.sv
module gs_gcl_store
    import gs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             locked,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  gs_entry_t        wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output gs_entry_t        rd_entry
);

    gs_entry_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && !locked && wr_idx == IDX_W'(i)) begin
                mem[i] <= wr_entry;
            end
        end

        // R5: list is frozen while the scheduler runs
        p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (locked && wr_en) |=> $stable(mem[i]))
            else $error("list entry changed while locked");
    end

    assign rd_entry = mem[rd_idx];

endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer
    import gs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  gs_time_t         time_ns,
    input  gs_time_t         base_slot,
    input  logic [CNT_W-1:0] n_entries,
    input  gs_entry_t        rd_entry,
    output logic [IDX_W-1:0] rd_idx,
    output logic             running,
    output gs_mask_t         run_gates,
    output logic             evt_strobe,
    output gs_time_t         evt_slot
);

    gs_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    gs_time_t         next_slot_q;
    logic [CNT_W-1:0] n_eff;
    logic [IDX_W-1:0] last_idx;
    logic             due;

    always_comb begin
        if (n_entries == '0) begin
            n_eff = CNT_W'(1);
        end else if (n_entries > CNT_W'(DEPTH)) begin
            n_eff = CNT_W'(DEPTH);
        end else begin
            n_eff = n_entries;
        end
        last_idx = IDX_W'(n_eff - CNT_W'(1));
    end

    assign due     = (time_ns >= slot_to_ns(next_slot_q));
    assign rd_idx  = idx_q;
    assign running = (state_q == SQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_IDLE;
            idx_q       <= '0;
            next_slot_q <= '0;
            run_gates   <= '0;
            evt_strobe  <= 1'b0;
            evt_slot    <= '0;
        end else begin
            evt_strobe <= 1'b0;
            if (!enable) begin
                state_q <= SQ_IDLE;
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        state_q     <= SQ_WAIT;
                        idx_q       <= '0;
                        next_slot_q <= base_slot;
                    end
                    SQ_WAIT, SQ_RUN: begin
                        if (due) begin
                            state_q     <= SQ_RUN;
                            run_gates   <= rd_entry.gates;
                            next_slot_q <= next_slot_q + gs_time_t'(rd_entry.interval);
                            idx_q       <= (idx_q >= last_idx) ? '0 : idx_q + IDX_W'(1);
                            evt_strobe  <= 1'b1;
                            evt_slot    <= next_slot_q;
                        end
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    // R1: no gate event follows a disabled cycle
    p_quiet_off_r1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !evt_strobe)
        else $error("event while disabled");

    // R10: back-to-back events never go backwards in slot order
    p_slot_order_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_strobe && $past(evt_strobe)) |-> (evt_slot >= $past(evt_slot)))
        else $error("event slots out of order");

    // R11: a disabled cycle leaves the run state
    p_leave_run_r11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !running)
        else $error("still running after disable");

endmodule

// File: rtl/gs_conflict.sv
module gs_conflict
    import gs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     own_strobe,
    input  gs_time_t own_slot,
    input  logic     peer_valid,
    input  gs_time_t peer_slot,
    output logic     conflict
);

    logic     have_own_q;
    logic     have_peer_q;
    gs_time_t last_own_q;
    gs_time_t last_peer_q;
    logic     own_hit;
    logic     peer_hit;

    always_comb begin
        own_hit = own_strobe &&
                  ((peer_valid && peer_slot == own_slot) ||
                   (have_own_q && last_own_q == own_slot) ||
                   (have_peer_q && last_peer_q == own_slot));
        peer_hit = peer_valid && have_own_q && (last_own_q == peer_slot);
    end

    assign conflict = own_hit || peer_hit;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            have_own_q  <= 1'b0;
            have_peer_q <= 1'b0;
            last_own_q  <= '0;
            last_peer_q <= '0;
        end else begin
            if (own_strobe) begin
                have_own_q <= 1'b1;
                last_own_q <= own_slot;
            end
            if (peer_valid) begin
                have_peer_q <= 1'b1;
                last_peer_q <= peer_slot;
            end
        end
    end

    // R7: a conflict always has an event behind it
    p_conflict_cause_r7: assert property (@(posedge clk) disable iff (rst)
        conflict |-> (own_strobe || peer_valid))
        else $error("conflict without any event");

    // R9: histories start empty after a disabled cycle
    p_history_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !active |=> !(peer_valid && !own_strobe && conflict))
        else $error("stale own history after disable");

endmodule

// File: rtl/gate_sched_port.sv
module gate_sched_port
    import gs_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int PORT_ID = 0,
    parameter int PORT_W  = 3,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [GS_TIME_W-1:0] time_ns,
    input  logic [GS_TIME_W-1:0] base_slot,
    input  logic [CNT_W-1:0]     n_entries,
    input  logic [GS_NUM_TC-1:0] idle_gates,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [GS_NUM_TC-1:0] wr_gates,
    input  logic [GS_IV_W-1:0]   wr_interval,
    input  logic                 peer_evt_valid,
    input  logic [GS_TIME_W-1:0] peer_evt_slot,
    output logic [GS_NUM_TC-1:0] gate_open,
    output logic                 evt_strobe,
    output logic [PORT_W-1:0]    evt_port,
    output logic [GS_TIME_W-1:0] evt_slot,
    output logic                 conflict
);

    gs_entry_t        wr_entry;
    gs_entry_t        rd_entry;
    logic [IDX_W-1:0] rd_idx;
    logic             running;
    gs_mask_t         run_gates;
    logic             strobe_int;
    gs_time_t         slot_int;

    assign wr_entry = '{gates: wr_gates, interval: wr_interval};

    gs_gcl_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .locked   (enable),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry)
    );

    gs_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .time_ns    (time_ns),
        .base_slot  (base_slot),
        .n_entries  (n_entries),
        .rd_entry   (rd_entry),
        .rd_idx     (rd_idx),
        .running    (running),
        .run_gates  (run_gates),
        .evt_strobe (strobe_int),
        .evt_slot   (slot_int)
    );

    gs_conflict u_conf (
        .clk        (clk),
        .rst        (rst),
        .active     (enable),
        .own_strobe (strobe_int),
        .own_slot   (slot_int),
        .peer_valid (peer_evt_valid),
        .peer_slot  (peer_evt_slot),
        .conflict   (conflict)
    );

    assign gate_open  = running ? run_gates : idle_gates;
    assign evt_strobe = strobe_int;
    assign evt_slot   = slot_int;
    assign evt_port   = PORT_W'(PORT_ID);

    // R2: an event is never raised before the time has reached its slot
    p_event_due_r2: assert property (@(posedge clk) disable iff (rst)
        strobe_int |-> (time_ns >= slot_to_ns(slot_int)))
        else $error("event ahead of its slot");

endmodule

// File: tb/sim_gate_sched_port.sv
module sim_gate_sched_port;

    localparam int CLK_PERIOD = 10;
    localparam int PID        = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [47:0] time_ns;
    logic [47:0] base_slot;
    logic [4:0]  n_entries;
    logic [7:0]  idle_gates;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [7:0]  wr_gates;
    logic [15:0] wr_interval;
    logic        peer_evt_valid;
    logic [47:0] peer_evt_slot;
    logic [7:0]  gate_open;
    logic        evt_strobe;
    logic [2:0]  evt_port;
    logic [47:0] evt_slot;
    logic        conflict;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gate_sched_port #(.DEPTH(16), .PORT_ID(PID), .PORT_W(3)) u0 (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .time_ns        (time_ns),
        .base_slot      (base_slot),
        .n_entries      (n_entries),
        .idle_gates     (idle_gates),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_gates       (wr_gates),
        .wr_interval    (wr_interval),
        .peer_evt_valid (peer_evt_valid),
        .peer_evt_slot  (peer_evt_slot),
        .gate_open      (gate_open),
        .evt_strobe     (evt_strobe),
        .evt_port       (evt_port),
        .evt_slot       (evt_slot),
        .conflict       (conflict)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_entry(input int idx, input logic [7:0] g, input logic [15:0] iv);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_gates = g; wr_interval = iv;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic expect_event(input string req, input logic [47:0] slot, input logic [7:0] g);
        check({req, " strobe"}, 64'(evt_strobe), 64'd1);
        check({req, " slot"}, 64'(evt_slot), 64'(slot));
        check({req, " gates"}, 64'(gate_open), 64'(g));
    endtask

    task automatic t_reset();
        check("R1 reset gates idle", 64'(gate_open), 64'hA5);
        check("R1 reset no strobe", 64'(evt_strobe), 64'd0);
        check("R7 reset no conflict", 64'(conflict), 64'd0);
    endtask

    task automatic t_before_base();
        base_slot = 48'd10; time_ns = 48'd0; enable = 1'b1;
        tick();
        time_ns = 48'd1999;
        tick();
        check("R1 before base gates idle", 64'(gate_open), 64'hA5);
        check("R1 before base no strobe", 64'(evt_strobe), 64'd0);
        // R5: write while enabled must not take
        write_entry(0, 8'h01, 16'd5);
    endtask

    task automatic t_first_event();
        time_ns = 48'd2000;
        tick();
        expect_event("R2 first event", 48'd10, 8'h80);
        check("R6 port index", 64'(evt_port), 64'(PID));
        tick();
        check("R2 strobe one cycle", 64'(evt_strobe), 64'd0);
    endtask

    task automatic t_sequence();
        time_ns = 48'd2399;
        tick();
        check("R3 one ns early no event", 64'(evt_strobe), 64'd0);
        check("R3 gates held", 64'(gate_open), 64'h80);
        time_ns = 48'd2400;
        tick();
        expect_event("R3 entry1", 48'd12, 8'h7F);
        time_ns = 48'd3000;
        tick();
        expect_event("R3 entry2", 48'd15, 8'h0F);
    endtask

    task automatic t_wrap();
        time_ns = 48'd3200;
        tick();
        expect_event("R4 R5 wrap to entry0", 48'd16, 8'h80);
        time_ns = 48'd3599;
        tick();
        check("R5 duration unchanged", 64'(evt_strobe), 64'd0);
    endtask

    task automatic t_catchup();
        time_ns = 48'd4200;
        tick();
        expect_event("R10 catchup first", 48'd18, 8'h7F);
        tick();
        expect_event("R10 catchup second", 48'd21, 8'h0F);
        tick();
        check("R10 caught up", 64'(evt_strobe), 64'd0);
    endtask

    task automatic t_conflict_peer();
        time_ns = 48'd4400; peer_evt_valid = 1'b1; peer_evt_slot = 48'd22;
        tick();
        expect_event("R7 same slot event", 48'd22, 8'h80);
        check("R7 same slot conflict", 64'(conflict), 64'd1);
        peer_evt_valid = 1'b0;
        tick();
        check("R7 conflict cleared", 64'(conflict), 64'd0);
        time_ns = 48'd4800; peer_evt_valid = 1'b1; peer_evt_slot = 48'd30;
        tick();
        expect_event("R7 other slot event", 48'd24, 8'h7F);
        check("R7 other slot no conflict", 64'(conflict), 64'd0);
        peer_evt_valid = 1'b0;
        tick();
    endtask

    task automatic t_conflict_late();
        peer_evt_valid = 1'b1; peer_evt_slot = 48'd24;
        tick();
        check("R9 late peer on own slot", 64'(conflict), 64'd1);
        peer_evt_slot = 48'd27;
        tick();
        check("R9 peer alone no conflict", 64'(conflict), 64'd0);
        peer_evt_valid = 1'b0; time_ns = 48'd5400;
        tick();
        expect_event("R9 own event", 48'd27, 8'h0F);
        check("R9 own on peer slot", 64'(conflict), 64'd1);
    endtask

    task automatic t_restart();
        enable = 1'b0; idle_gates = 8'hFF;
        tick();
        check("R11 idle after disable", 64'(gate_open), 64'hFF);
        check("R1 no strobe disabled", 64'(evt_strobe), 64'd0);
        enable = 1'b1;
        tick();
        check("R11 armed gates idle", 64'(gate_open), 64'hFF);
        tick();
        expect_event("R11 restart entry0", 48'd10, 8'h80);
        enable = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_self_conflict();
        write_entry(1, 8'h3C, 16'd0);
        time_ns = 48'd0; enable = 1'b1;
        tick();
        time_ns = 48'd2000;
        tick();
        expect_event("R8 first", 48'd10, 8'h80);
        check("R8 first no conflict", 64'(conflict), 64'd0);
        time_ns = 48'd2400;
        tick();
        expect_event("R5 R8 new mask", 48'd12, 8'h3C);
        check("R8 second no conflict", 64'(conflict), 64'd0);
        tick();
        expect_event("R8 zero length", 48'd12, 8'h0F);
        check("R8 same slot conflict", 64'(conflict), 64'd1);
        enable = 1'b0;
        tick();
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; time_ns = '0; base_slot = '0; n_entries = 5'd3;
        idle_gates = 8'hA5; wr_en = 1'b0; wr_idx = '0; wr_gates = '0; wr_interval = '0;
        peer_evt_valid = 1'b0; peer_evt_slot = '0;
        tick();
        tick();
        rst = 1'b0;
        tick();
        t_reset();
        write_entry(0, 8'h80, 16'd2);
        write_entry(1, 8'h7F, 16'd3);
        write_entry(2, 8'h0F, 16'd1);
        t_before_base();
        t_first_event();
        t_sequence();
        t_wrap();
        t_catchup();
        t_conflict_peer();
        t_conflict_late();
        t_restart();
        t_self_conflict();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule